// File: doc/BRIEF.md
# Statically Tagged Speculative Reorder Buffer

This block is a circular reorder buffer with eight slots. Instructions enter it at issue in program order. The compiler marks each instruction either as plain or as speculative. A speculative instruction also carries a list of up to two branches that it was scheduled ahead of, and the direction the compiler assumed for each one.

The buffer does four things with that information:
- It records completion results as they arrive, in any order.
- It watches a branch-resolve port and compares each outcome with the directions the compiler assumed.
- It retires at most one entry per cycle, always the oldest.
- It withholds the register write of a speculative result until every branch that result crossed has resolved.

Nothing outside the buffer ever sees a speculative result on a wrong path. If a branch resolves against the assumed direction, the entry is cancelled. It then retires silently: no register write and no exception. An exception recorded at completion is raised only when the entry retires on the correct path. Execution units and the register file sit outside the block. Their completion and write-back interfaces are the ports described below.

Top module: `spec_rob`

## Requirements
- R1: After reset, `iss_ready` is 1, `iss_idx` is 0 and `ret_valid` is 0.
- R2: Issue is accepted when `iss_valid` and `iss_ready` are both 1.
  - `iss_idx` names the slot the accepted entry takes. It steps by one modulo 8 on each accepted issue.
  - With 8 unretired entries, `iss_ready` is 0. An issue attempt while `iss_ready` is 0 is ignored.
- R3: Entries retire strictly oldest first, at most one per cycle. A younger entry that has completed waits behind an older one that cannot retire.
- R4: A plain entry (`iss_spec`=0; its branch fields are ignored) may retire once completed without an exception.
  - The completion is accepted at a clock edge.
  - In the cycle after that edge, if the entry is the oldest, `ret_valid`=1 and `wb_en`=1.
  - `wb_dest` and `wb_data` carry the issued destination and the completed data.
- R5: A speculative entry (`iss_spec`=1) crosses `min(iss_nbr,2)` branches. Branch i uses tag `iss_btag[3*i+2:3*i]` and assumed direction `iss_dir[i]` (1 = taken). The entry cannot retire normally until each of those branches has been resolved.
- R6: A resolve (`brr_valid`=1) whose `brr_tag` matches an unresolved crossed branch of a live entry marks that branch resolved. If `brr_taken` equals the assumed direction, the entry later retires with its normal write-back.
- R7: If a crossed branch resolves opposite to its assumed direction, the entry is cancelled.
  - A cancelled entry retires as soon as it is oldest, whether or not it has completed.
  - It retires with `ret_cancel`=1, `wb_en`=0 and `exc_raise`=0.
- R8: An entry completed with `cmp_exc`=1 retires with `exc_raise`=1 and `wb_en`=0, unless it is cancelled.
- R9: A completion aimed at a slot that holds no live entry has no effect. A later entry issued into that slot still waits for its own completion.
- R10: A resolve in the same cycle as the issue of an entry that crosses that branch tag is applied to the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Buffer has a free slot |
| iss_idx | output | 3 | Slot the next issued entry takes |
| iss_dest | input | 5 | Destination register of the issued entry |
| iss_spec | input | 1 | Entry was hoisted by the compiler |
| iss_nbr | input | 2 | Number of crossed branches (3 acts as 2) |
| iss_btag | input | 6 | Tags of crossed branches, 3 bits each, branch 0 lowest |
| iss_dir | input | 2 | Assumed direction of each crossed branch, 1 = taken |
| cmp_valid | input | 1 | Completion strobe |
| cmp_idx | input | 3 | Slot that completed |
| cmp_data | input | 16 | Result value |
| cmp_exc | input | 1 | Completion raised an exception |
| brr_valid | input | 1 | Branch resolve strobe |
| brr_tag | input | 3 | Tag of the resolved branch |
| brr_taken | input | 1 | Actual direction, 1 = taken |
| ret_valid | output | 1 | Oldest entry retires this cycle |
| ret_idx | output | 3 | Slot of the retiring entry |
| ret_cancel | output | 1 | Retiring entry was cancelled |
| wb_en | output | 1 | Register write for the retiring entry |
| wb_dest | output | 5 | Destination register of the write |
| wb_data | output | 16 | Value to write |
| exc_raise | output | 1 | Retiring entry raises its exception |

## Verification
Every output is decoded from registered state only, so each issue, completion or resolve sampled at one edge becomes visible right after that edge. A retirement shown in one cycle frees its slot at the next edge. The bench therefore drives inputs just after an edge and compares outputs 4 ns later, before the following edge. Its reference model updates only after that edge, using the inputs and the expected retirement held from before it. Directed sequences pin down gating on two branches, same-cycle resolve, stray completions and the full buffer. A seeded random phase mixes all four streams.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;
    localparam int ROB_DEPTH = 8;
    localparam int BR_MAX    = 2;
    localparam int BTAG_W    = 3;
    localparam int DATA_W    = 16;
    localparam int REG_W     = 5;
    localparam int IDX_W     = $clog2(ROB_DEPTH);
    localparam int NBR_W     = $clog2(BR_MAX + 1);

    typedef struct packed {
        logic                     valid;
        logic                     done;
        logic                     cancel;
        logic                     exc;
        logic [BR_MAX-1:0]        pend;
        logic [BR_MAX-1:0]        dir;
        logic [BR_MAX*BTAG_W-1:0] btag;
        logic [REG_W-1:0]         dest;
        logic [DATA_W-1:0]        data;
    } slot_t;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic          full
);
    typedef struct packed {
        logic [IW-1:0] head;
        logic [IW-1:0] tail;
        logic          full;
    } ptr_t;

    ptr_t q, d;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
    endfunction

    always_comb begin
        d = q;
        if (push) d.tail = nxt(q.tail);
        if (pop)  d.head = nxt(q.head);
        if (push && !pop && nxt(q.tail) == q.head) d.full = 1'b1;
        else if (pop && !push)                     d.full = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head = q.head;
    assign tail = q.tail;
    assign full = q.full;

    AST_FULL_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        q.full |-> q.head == q.tail); // R2
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.head == q.tail && !q.full) |-> !pop); // R3
endmodule

// File: rtl/rob_slot.sv
module rob_slot
    import spec_rob_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic                     iss_spec,
    input  logic [NBR_W-1:0]         iss_nbr,
    input  logic [BR_MAX*BTAG_W-1:0] iss_btag,
    input  logic [BR_MAX-1:0]        iss_dir,
    input  logic [REG_W-1:0]         iss_dest,
    input  logic                     cmp_hit,
    input  logic [DATA_W-1:0]        cmp_data,
    input  logic                     cmp_exc,
    input  logic                     brr_valid,
    input  logic [BTAG_W-1:0]        brr_tag,
    input  logic                     brr_taken,
    input  logic                     clr,
    output slot_t                    q
);
    slot_t d;

    always_comb begin
        d = q;
        if (clr) d.valid = 1'b0;
        if (wr) begin
            d.valid  = 1'b1;
            d.done   = 1'b0;
            d.cancel = 1'b0;
            d.exc    = 1'b0;
            d.dest   = iss_dest;
            d.data   = '0;
            d.dir    = iss_dir;
            d.btag   = iss_btag;
            for (int i = 0; i < BR_MAX; i++)
                d.pend[i] = iss_spec && (int'(iss_nbr) > i);
        end
        if (cmp_hit && q.valid) begin
            d.done = 1'b1;
            d.data = cmp_data;
            d.exc  = cmp_exc;
        end
        if (brr_valid && d.valid) begin
            for (int i = 0; i < BR_MAX; i++) begin
                if (d.pend[i] && d.btag[i*BTAG_W +: BTAG_W] == brr_tag) begin
                    d.pend[i] = 1'b0;
                    if (brr_taken != d.dir[i]) d.cancel = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CANCEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && q.cancel && !clr) |=> q.cancel); // R7
    AST_NO_WR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && q.valid) |-> clr); // R2
endmodule

// File: rtl/rob_commit.sv
module rob_commit
    import spec_rob_pkg::*;
(
    input  slot_t head_slot,
    output logic  retire,
    output logic  cancel,
    output logic  wb_en,
    output logic  exc_raise
);
    logic ready_ok;

    always_comb begin
        ready_ok  = head_slot.done && (head_slot.pend == '0);
        retire    = head_slot.valid && (head_slot.cancel || ready_ok);
        cancel    = retire && head_slot.cancel;
        wb_en     = retire && !head_slot.cancel && !head_slot.exc;
        exc_raise = retire && !head_slot.cancel && head_slot.exc;
    end
endmodule

// File: rtl/spec_rob.sv
module spec_rob
    import spec_rob_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     iss_valid,
    output logic                     iss_ready,
    output logic [IDX_W-1:0]         iss_idx,
    input  logic [REG_W-1:0]         iss_dest,
    input  logic                     iss_spec,
    input  logic [NBR_W-1:0]         iss_nbr,
    input  logic [BR_MAX*BTAG_W-1:0] iss_btag,
    input  logic [BR_MAX-1:0]        iss_dir,
    input  logic                     cmp_valid,
    input  logic [IDX_W-1:0]         cmp_idx,
    input  logic [DATA_W-1:0]        cmp_data,
    input  logic                     cmp_exc,
    input  logic                     brr_valid,
    input  logic [BTAG_W-1:0]        brr_tag,
    input  logic                     brr_taken,
    output logic                     ret_valid,
    output logic [IDX_W-1:0]         ret_idx,
    output logic                     ret_cancel,
    output logic                     wb_en,
    output logic [REG_W-1:0]         wb_dest,
    output logic [DATA_W-1:0]        wb_data,
    output logic                     exc_raise
);
    logic [IDX_W-1:0] head, tail;
    logic             full, push, retire;
    slot_t            slots [ROB_DEPTH];
    slot_t            head_slot;

    assign push = iss_valid && !full;

    rob_ptr #(.DEPTH(ROB_DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(retire),
        .head(head), .tail(tail), .full(full)
    );

    for (genvar g = 0; g < ROB_DEPTH; g++) begin : g_slot
        rob_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr(push && tail == IDX_W'(g)),
            .iss_spec(iss_spec), .iss_nbr(iss_nbr), .iss_btag(iss_btag),
            .iss_dir(iss_dir), .iss_dest(iss_dest),
            .cmp_hit(cmp_valid && cmp_idx == IDX_W'(g)),
            .cmp_data(cmp_data), .cmp_exc(cmp_exc),
            .brr_valid(brr_valid), .brr_tag(brr_tag), .brr_taken(brr_taken),
            .clr(retire && head == IDX_W'(g)),
            .q(slots[g])
        );
    end

    assign head_slot = slots[head];

    rob_commit u_commit (
        .head_slot(head_slot), .retire(retire), .cancel(ret_cancel),
        .wb_en(wb_en), .exc_raise(exc_raise)
    );

    assign iss_ready = !full;
    assign iss_idx   = tail;
    assign ret_valid = retire;
    assign ret_idx   = head;
    assign wb_dest   = head_slot.dest;
    assign wb_data   = head_slot.data;

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (!ret_valid || ret_idx == IDX_W'($past(ret_idx) + 1'b1))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> iss_idx == $past(iss_idx)); // R2
    AST_SPEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_cancel) |-> (head_slot.pend == '0 && head_slot.done)); // R5
    AST_WB_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (head_slot.done && !head_slot.exc && !head_slot.cancel)); // R4
    AST_CANCEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && head_slot.cancel) |-> (!wb_en && !exc_raise)); // R7
endmodule

// File: tb/sim_spec_rob.sv
module sim_spec_rob;
    logic        clk = 0, rst_n = 0;
    logic        iss_valid = 0, iss_spec = 0;
    logic [4:0]  iss_dest = 0;
    logic [1:0]  iss_nbr = 0, iss_dir = 0;
    logic [5:0]  iss_btag = 0;
    logic        cmp_valid = 0, cmp_exc = 0;
    logic [2:0]  cmp_idx = 0;
    logic [15:0] cmp_data = 0;
    logic        brr_valid = 0, brr_taken = 0;
    logic [2:0]  brr_tag = 0;
    logic        iss_ready, ret_valid, ret_cancel, wb_en, exc_raise;
    logic [2:0]  iss_idx, ret_idx;
    logic [4:0]  wb_dest;
    logic [15:0] wb_data;

    spec_rob u0 (.*);

    always #5 clk = ~clk;

    int n_run = 0, n_fail = 0;
    bit done_flag = 0;

    // reference model state
    bit m_valid[8], m_done[8], m_cancel[8], m_exc[8];
    bit m_pend[8][2], m_dir[8][2];
    int m_tag[8][2], m_dest[8], m_data[8];
    int m_head = 0, m_tail = 0, m_cnt = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_ret();
        int h = m_head;
        return m_valid[h] && (m_cancel[h] || (m_done[h] && !m_pend[h][0] && !m_pend[h][1]));
    endfunction

    task automatic step();
        bit er, erdy;
        bit pv[8];
        int h;
        #4;
        er = exp_ret(); erdy = (m_cnt < 8); h = m_head;
        chk(iss_ready == erdy, "R2", "iss_ready", iss_ready, erdy);
        chk(iss_idx == 3'(m_tail), "R2", "iss_idx", iss_idx, m_tail);
        chk(ret_valid == er, "R3", "ret_valid", ret_valid, er);
        if (er) begin
            chk(ret_idx == 3'(h), "R3", "ret_idx", ret_idx, h);
            chk(ret_cancel == m_cancel[h], "R7", "ret_cancel", ret_cancel, m_cancel[h]);
            chk(wb_en == (!m_cancel[h] && !m_exc[h]), "R4", "wb_en", wb_en,
                !m_cancel[h] && !m_exc[h]);
            chk(exc_raise == (!m_cancel[h] && m_exc[h]), "R8", "exc_raise", exc_raise,
                !m_cancel[h] && m_exc[h]);
            if (!m_cancel[h] && !m_exc[h]) begin
                chk(wb_dest == 5'(m_dest[h]), "R4", "wb_dest", wb_dest, m_dest[h]);
                chk(wb_data == 16'(m_data[h]), "R6", "wb_data", wb_data, m_data[h]);
            end
        end
        for (int j = 0; j < 8; j++) pv[j] = m_valid[j];
        @(posedge clk); #1;
        if (!rst_n) return;
        if (er) begin
            m_valid[h] = 0; m_head = (m_head + 1) % 8; m_cnt--;
        end
        if (iss_valid && erdy) begin
            int t = m_tail;
            m_valid[t] = 1; m_done[t] = 0; m_cancel[t] = 0; m_exc[t] = 0;
            m_dest[t] = iss_dest; m_data[t] = 0;
            for (int i = 0; i < 2; i++) begin
                m_pend[t][i] = iss_spec && (int'(iss_nbr) > i);
                m_dir[t][i]  = iss_dir[i];
                m_tag[t][i]  = int'(iss_btag[3*i +: 3]);
            end
            m_tail = (m_tail + 1) % 8; m_cnt++;
        end
        if (cmp_valid && pv[cmp_idx]) begin
            m_done[cmp_idx] = 1; m_data[cmp_idx] = cmp_data; m_exc[cmp_idx] = cmp_exc;
        end
        if (brr_valid)
            for (int j = 0; j < 8; j++)
                if (m_valid[j])
                    for (int i = 0; i < 2; i++)
                        if (m_pend[j][i] && m_tag[j][i] == int'(brr_tag)) begin
                            m_pend[j][i] = 0;
                            if (brr_taken != m_dir[j][i]) m_cancel[j] = 1;
                        end
    endtask

    task automatic idle();
        iss_valid = 0; cmp_valid = 0; brr_valid = 0; cmp_exc = 0;
    endtask

    task automatic drain();
        for (int c = 0; c < 200 && m_cnt > 0; c++) begin
            idle();
            cmp_valid = 1; cmp_idx = 3'(m_head); cmp_data = 16'($urandom);
            brr_valid = 1; brr_tag = 3'(c); brr_taken = 1'($urandom);
            step();
        end
        idle(); step();
    endtask

    task automatic issue(input bit sp, input int nbr, input int t0, input int t1,
                         input int dr, input int dst);
        iss_valid = 1; iss_spec = sp; iss_nbr = 2'(nbr);
        iss_btag = {3'(t1), 3'(t0)}; iss_dir = 2'(dr); iss_dest = 5'(dst);
    endtask

    initial begin
        #(200000 * 10);
        if (!done_flag) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(iss_ready == 1, "R1", "iss_ready", iss_ready, 1);
        chk(iss_idx == 0, "R1", "iss_idx", iss_idx, 0);
        chk(ret_valid == 0, "R1", "ret_valid", ret_valid, 0);
        rst_n = 1;
        @(posedge clk); #1;

        // R2: fill to capacity, extra issue ignored
        for (int k = 0; k < 9; k++) begin
            idle(); issue(0, 0, 0, 0, 0, k + 1); step();
        end
        chk(iss_ready == 0, "R2", "full ready", iss_ready, 0);
        // R3: younger completion waits
        idle(); cmp_valid = 1; cmp_idx = 3; cmp_data = 16'h0333; step();
        chk(ret_valid == 0, "R3", "young waits", ret_valid, 0);
        // R4: head completion retires next cycle with write-back
        idle(); cmp_valid = 1; cmp_idx = 0; cmp_data = 16'h0a0a; step();
        chk(ret_valid == 1 && wb_en == 1 && wb_data == 16'h0a0a, "R4", "head wb",
            wb_data, 16'h0a0a);
        drain();

        // R9: stray completion to empty slot
        idle(); cmp_valid = 1; cmp_idx = 3'(m_tail); cmp_data = 16'h1111; step();
        idle(); issue(0, 0, 0, 0, 0, 7); step();
        idle(); step();
        chk(ret_valid == 0, "R9", "stray completion", ret_valid, 0);
        drain();

        // R5 / R6: two crossed branches
        idle(); issue(1, 2, 4, 5, 2'b01, 9); step();
        idle(); cmp_valid = 1; cmp_idx = 3'((m_tail + 7) % 8); cmp_data = 16'h5555; step();
        chk(ret_valid == 0, "R5", "both pending", ret_valid, 0);
        idle(); brr_valid = 1; brr_tag = 4; brr_taken = 1; step();
        chk(ret_valid == 0, "R5", "one pending", ret_valid, 0);
        idle(); brr_valid = 1; brr_tag = 5; brr_taken = 0; step();
        chk(ret_valid == 1 && wb_en == 1 && ret_cancel == 0, "R6", "resolved ok",
            wb_en, 1);
        drain();

        // R7 / R10: same-cycle mismatching resolve cancels without completion
        idle(); issue(1, 1, 2, 0, 2'b01, 3); brr_valid = 1; brr_tag = 2; brr_taken = 0;
        step();
        chk(ret_valid == 1 && ret_cancel == 1 && wb_en == 0, "R10", "same-cycle cancel",
            ret_cancel, 1);
        drain();

        // R8: exception raised at retirement
        idle(); issue(0, 0, 0, 0, 0, 4); step();
        idle(); cmp_valid = 1; cmp_idx = 3'((m_tail + 7) % 8); cmp_exc = 1; step();
        chk(exc_raise == 1 && wb_en == 0, "R8", "exc at retire", exc_raise, 1);
        drain();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            idle();
            if ($urandom % 2 == 0)
                issue($urandom % 2 == 0, $urandom % 4, $urandom % 8, $urandom % 8,
                      $urandom % 4, $urandom % 32);
            if ($urandom % 10 < 6) begin
                cmp_valid = 1; cmp_idx = 3'($urandom); cmp_data = 16'($urandom);
                cmp_exc = ($urandom % 8 == 0);
            end
            if ($urandom % 10 < 3) begin
                brr_valid = 1; brr_tag = 3'($urandom); brr_taken = 1'($urandom);
            end
            step();
        end
        drain();

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule